// File: doc/BRIEF.md
# Transmit DMA Channel Engine

This block serves one transmit channel. It waits until its transmit queue reports pending work, then pops a descriptor pointer, reads a four-word packet descriptor from memory, and sends the packet payload one word per beat on a valid/ready stream with a last-beat marker. The payload may be spread over a chain of buffers. Each buffer descriptor names the next one, and the engine follows the chain until the packet length is used up. It then hands the original descriptor pointer back to the return queue named in the first descriptor. If the chain runs out before the packet length is reached, the engine flags an error on that return push.

The engine moves the payload in block moves. A block is at most `BLOCK` words long and never runs past the end of the current buffer. All lengths count 32-bit words. Memory is word-addressed and returns read data exactly one cycle after the read strobe. The queue head pointer is valid whenever the pending status is high, and a pop is a one-cycle strobe.

Top module: `txdma_engine`

## Requirements
- R1: After reset, and for as long as the queue status stays low in idle, `popO`, `memRdO`, `tValidO` and `pushO` stay low.
- R2: When the queue status is high, the engine pops exactly once. Its first four memory reads are the descriptor words at pointer+0, +1, +2 and +3, in that order.
- R3: Descriptor layout: word 0 is the packet length in words, word 1 is the buffer start address, and word 2 is the buffer length in words. In word 3, bits [15:0] hold the next-descriptor pointer and bits [31:16] hold the return queue number.
- R4: The payload appears on `tDataO` as the memory words of each buffer in ascending address order. The number of beats equals the packet length.
- R5: A nonzero next pointer is followed when a buffer is used up. For a chained descriptor only words 1 to 3 are read, never word 0. A buffer of length zero contributes no beats.
- R6: When the packet length runs out inside a buffer, the rest of that buffer and any later link are ignored: no further payload or descriptor reads are made.
- R7: `tLastO` is high on the final beat of a complete packet and on no other beat.
- R8: After a packet, exactly one push is made. It carries the first descriptor's pointer and the return queue from the first descriptor, with `errO` low. Return fields in chained descriptors are ignored.
- R9: If a zero next pointer ends the chain before the packet length is reached, the buffers present are sent without `tLastO`. The pointer is still pushed, with `errO` high.
- R10: While a beat is held by `tReadyI` low, `tDataO` and `tLastO` stay stable, `tValidO` stays high and no memory read is issued. No beat is lost or repeated.
- R11: Several pointers queued back to back are processed in pop order, each with its own push.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| qPendingI | input | 1 | Transmit queue non-empty level |
| popO | output | 1 | Pop strobe to the queue |
| popPtrI | input | 16 | Head descriptor pointer of the queue |
| memRdO | output | 1 | Memory read strobe |
| memAddrO | output | 16 | Memory word address |
| memDataI | input | 32 | Read data, one cycle after the strobe |
| tValidO | output | 1 | Stream beat valid |
| tReadyI | input | 1 | Stream sink ready |
| tDataO | output | 32 | Stream beat data |
| tLastO | output | 1 | Final beat of the packet |
| pushO | output | 1 | Return push strobe |
| pushPtrO | output | 16 | Descriptor pointer being returned |
| pushQueueO | output | 16 | Return queue number |
| errO | output | 1 | Chain ended short; valid with pushO |

## Verification
The bench builds a three-link chain whose middle buffer is empty and whose last descriptor carries a different return queue. An engine that reads word 0 of a link, emits a beat for an empty buffer, or takes the return queue from the wrong link fails the read-address, beat-count or queue checks. A packet shorter than its buffer, with a stray next pointer, shows whether the engine stops at the length or runs on. A chain that ends early must give a push with the error flag and no last marker. An irregular ready pattern catches beats that are dropped, repeated or changed while stalled, and memory reads issued during a stall. Two pointers queued together check that the engine returns to idle and takes the second packet in order.

// File: rtl/txdma_pkg.sv
package txdma_pkg;
  // control -> datapath strobes
  typedef struct packed {
    logic popTake;
    logic descRd;
    logic descCap;
    logic chainNext;
    logic chainErr;
    logic blkLoad;
    logic beatRd;
    logic beatCap;
    logic beatAdv;
    logic finish;
  } ctlStrobe_t;

  // datapath -> control status
  typedef struct packed {
    logic pktZero;
    logic bufZero;
    logic nextZero;
    logic idxLast;
    logic blkLast;
    logic lastBeat;
  } dpStat_t;
endpackage

// File: rtl/txdma_ctrl.sv
module txdma_ctrl
  import txdma_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       qPendingI,
  input  logic       tReadyI,
  input  dpStat_t    stat,
  output ctlStrobe_t st,
  output logic       popO,
  output logic       memRdO,
  output logic       tValidO,
  output logic       pushO
);
  typedef enum logic [3:0] {
    S_IDLE, S_POP, S_DRD, S_DCAP, S_CHK, S_BRD, S_BCAP, S_BOUT, S_DONE
  } state_t;

  state_t state, nextState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    st = '0;
    nextState = state;
    unique case (state)
      S_IDLE: if (qPendingI) nextState = S_POP;
      S_POP: begin
        st.popTake = 1'b1;
        nextState = S_DRD;
      end
      S_DRD: begin
        st.descRd = 1'b1;
        nextState = S_DCAP;
      end
      S_DCAP: begin
        st.descCap = 1'b1;
        nextState = stat.idxLast ? S_CHK : S_DRD;
      end
      S_CHK: begin
        if (stat.pktZero) begin
          nextState = S_DONE;
        end else if (stat.bufZero) begin
          if (stat.nextZero) begin
            st.chainErr = 1'b1;
            nextState = S_DONE;
          end else begin
            st.chainNext = 1'b1;
            nextState = S_DRD;
          end
        end else begin
          st.blkLoad = 1'b1;
          nextState = S_BRD;
        end
      end
      S_BRD: begin
        st.beatRd = 1'b1;
        nextState = S_BCAP;
      end
      S_BCAP: begin
        st.beatCap = 1'b1;
        nextState = S_BOUT;
      end
      S_BOUT: begin
        if (tReadyI) begin
          st.beatAdv = 1'b1;
          nextState = stat.blkLast ? S_CHK : S_BRD;
        end
      end
      S_DONE: begin
        st.finish = 1'b1;
        nextState = S_IDLE;
      end
      default: nextState = S_IDLE;
    endcase
  end

  assign popO    = st.popTake;
  assign memRdO  = st.descRd | st.beatRd;
  assign tValidO = (state == S_BOUT);
  assign pushO   = st.finish;

  // R1: a pop is only issued against a non-empty queue
  a_r1_pop_needs_pending: assert property (@(posedge clk) disable iff (!rstN)
    popO |-> qPendingI);
  // R10: no memory traffic while a beat is on the stream
  a_r10_no_read_when_valid: assert property (@(posedge clk) disable iff (!rstN)
    tValidO |-> !memRdO);
  // R8: one push per packet
  a_r8_single_push: assert property (@(posedge clk) disable iff (!rstN)
    pushO |=> !pushO);
endmodule

// File: rtl/txdma_dpath.sv
module txdma_dpath
  import txdma_pkg::*;
#(
  parameter int AW    = 16,
  parameter int DW    = 32,
  parameter int QW    = 16,
  parameter int LW    = 16,
  parameter int BLOCK = 4
) (
  input  logic          clk,
  input  logic          rstN,
  input  ctlStrobe_t    st,
  input  logic [AW-1:0] popPtrI,
  input  logic [DW-1:0] memDataI,
  output logic [AW-1:0] memAddrO,
  output logic [DW-1:0] tDataO,
  output logic [AW-1:0] pushPtrO,
  output logic [QW-1:0] pushQueueO,
  output logic          errFlagO,
  output dpStat_t       stat
);
  localparam int HALF = DW / 2;
  localparam logic [LW-1:0] BLK_L = LW'(BLOCK);

  logic [AW-1:0] headPtr, curPtr, bufAddr, nextPtr;
  logic [1:0]    idx;
  logic          first;
  logic [LW-1:0] pktLeft, bufLeft, blkCnt;
  logic [QW-1:0] retQ;
  logic [DW-1:0] outData;
  logic          errFlag;
  logic [LW-1:0] lenMin, blkLen;

  always_comb begin
    lenMin = (bufLeft < pktLeft) ? bufLeft : pktLeft;
    blkLen = (lenMin < BLK_L) ? lenMin : BLK_L;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      headPtr <= '0; curPtr <= '0; bufAddr <= '0; nextPtr <= '0;
      idx <= '0; first <= 1'b0; pktLeft <= '0; bufLeft <= '0;
      blkCnt <= '0; retQ <= '0; outData <= '0; errFlag <= 1'b0;
    end else begin
      if (st.popTake) begin
        headPtr <= popPtrI;
        curPtr  <= popPtrI;
        idx     <= 2'd0;
        first   <= 1'b1;
        errFlag <= 1'b0;
      end
      if (st.descCap) begin
        idx <= idx + 2'd1;
        case (idx)
          2'd0: pktLeft <= memDataI[LW-1:0];
          2'd1: bufAddr <= memDataI[AW-1:0];
          2'd2: bufLeft <= memDataI[LW-1:0];
          default: begin
            nextPtr <= memDataI[AW-1:0];
            if (first) retQ <= memDataI[HALF +: QW];
          end
        endcase
      end
      if (st.chainNext) begin
        curPtr <= nextPtr;
        idx    <= 2'd1;
        first  <= 1'b0;
      end
      if (st.chainErr) errFlag <= 1'b1;
      if (st.blkLoad)  blkCnt  <= blkLen;
      if (st.beatCap)  outData <= memDataI;
      if (st.beatAdv) begin
        bufAddr <= bufAddr + AW'(1);
        bufLeft <= bufLeft - LW'(1);
        pktLeft <= pktLeft - LW'(1);
        blkCnt  <= blkCnt - LW'(1);
      end
    end
  end

  assign memAddrO   = st.descRd ? (curPtr + AW'(idx)) : bufAddr;
  assign tDataO     = outData;
  assign pushPtrO   = headPtr;
  assign pushQueueO = retQ;
  assign errFlagO   = errFlag;

  assign stat.pktZero  = (pktLeft == '0);
  assign stat.bufZero  = (bufLeft == '0);
  assign stat.nextZero = (nextPtr == '0);
  assign stat.idxLast  = (idx == 2'd3);
  assign stat.blkLast  = (blkCnt == LW'(1));
  assign stat.lastBeat = (pktLeft == LW'(1));

  // R6: a beat never advances past the packet, the buffer or the block
  a_r6_no_underflow: assert property (@(posedge clk) disable iff (!rstN)
    st.beatAdv |-> (pktLeft != '0 && bufLeft != '0 && blkCnt != '0));
  // R4: a block never exceeds the configured block size
  a_r4_block_bound: assert property (@(posedge clk) disable iff (!rstN)
    st.blkLoad |=> (blkCnt <= BLK_L && blkCnt != '0));
endmodule

// File: rtl/txdma_engine.sv
module txdma_engine
  import txdma_pkg::*;
#(
  parameter int AW    = 16,
  parameter int DW    = 32,
  parameter int QW    = 16,
  parameter int LW    = 16,
  parameter int BLOCK = 4
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          qPendingI,
  output logic          popO,
  input  logic [AW-1:0] popPtrI,
  output logic          memRdO,
  output logic [AW-1:0] memAddrO,
  input  logic [DW-1:0] memDataI,
  output logic          tValidO,
  input  logic          tReadyI,
  output logic [DW-1:0] tDataO,
  output logic          tLastO,
  output logic          pushO,
  output logic [AW-1:0] pushPtrO,
  output logic [QW-1:0] pushQueueO,
  output logic          errO
);
  ctlStrobe_t st;
  dpStat_t    stat;
  logic       errFlag;

  txdma_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .qPendingI(qPendingI), .tReadyI(tReadyI),
    .stat(stat), .st(st), .popO(popO), .memRdO(memRdO),
    .tValidO(tValidO), .pushO(pushO)
  );

  txdma_dpath #(.AW(AW), .DW(DW), .QW(QW), .LW(LW), .BLOCK(BLOCK)) u_dpath (
    .clk(clk), .rstN(rstN), .st(st), .popPtrI(popPtrI), .memDataI(memDataI),
    .memAddrO(memAddrO), .tDataO(tDataO), .pushPtrO(pushPtrO),
    .pushQueueO(pushQueueO), .errFlagO(errFlag), .stat(stat)
  );

  assign tLastO = tValidO & stat.lastBeat;
  assign errO   = pushO & errFlag;

  // R10: a stalled beat is held unchanged
  a_r10_hold_beat: assert property (@(posedge clk) disable iff (!rstN)
    (tValidO && !tReadyI) |=> (tValidO && $stable(tDataO) && $stable(tLastO)));
  // R7: the last beat closes the packet stream
  a_r7_last_ends_packet: assert property (@(posedge clk) disable iff (!rstN)
    (tValidO && tReadyI && tLastO) |=> !tValidO);
endmodule

// File: tb/sim_txdma_engine.sv
`timescale 1ns/1ps
module sim_txdma_engine;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        qPendingI;
  logic        popO;
  logic [15:0] popPtrI;
  logic        memRdO;
  logic [15:0] memAddrO;
  logic [31:0] memDataI = '0;
  logic        tValidO;
  logic        tReadyI = 1'b1;
  logic [31:0] tDataO;
  logic        tLastO;
  logic        pushO;
  logic [15:0] pushPtrO;
  logic [15:0] pushQueueO;
  logic        errO;

  always #10 clk = ~clk;

  txdma_engine u0 (.*);

  int checks = 0;
  int errors = 0;

  // memory model
  logic [31:0] mem [0:255];
  always @(posedge clk) memDataI <= memRdO ? mem[memAddrO[7:0]] : 32'hBAD0BAD0;

  // queue model
  logic [15:0] qPtr [0:15];
  logic [3:0]  qHead = '0;
  logic [3:0]  qTail = '0;
  assign qPendingI = (qHead != qTail);
  assign popPtrI   = qPtr[qHead];
  always @(posedge clk) if (rstN && popO) qHead <= qHead + 4'd1;

  // logs
  logic [15:0] rdLog [0:255];
  logic [31:0] bD [0:255];
  logic        bL [0:255];
  logic [15:0] pP [0:15];
  logic [15:0] pQ [0:15];
  logic        pE [0:15];
  int rdN = 0, bN = 0, pN = 0, popN = 0, stallRd = 0, holdBad = 0;
  logic        prevStall = 1'b0;
  logic [31:0] prevData = '0;
  logic        prevLast = 1'b0;

  always @(posedge clk) if (rstN) begin
    if (memRdO) begin rdLog[rdN[7:0]] <= memAddrO; rdN <= rdN + 1; end
    if (tValidO && tReadyI) begin
      bD[bN[7:0]] <= tDataO; bL[bN[7:0]] <= tLastO; bN <= bN + 1;
    end
    if (pushO) begin
      pP[pN[3:0]] <= pushPtrO; pQ[pN[3:0]] <= pushQueueO; pE[pN[3:0]] <= errO;
      pN <= pN + 1;
    end
    if (popO) popN <= popN + 1;
    if (tValidO && !tReadyI && memRdO) stallRd <= stallRd + 1;
    if (prevStall && (!tValidO || tDataO != prevData || tLastO != prevLast))
      holdBad <= holdBad + 1;
    prevStall <= tValidO && !tReadyI;
    prevData  <= tDataO;
    prevLast  <= tLastO;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic setDesc(input int p, input int len, input int buf0, input int blen,
                         input int nxt, input int rq);
    mem[p]   = 32'(len);
    mem[p+1] = 32'(buf0);
    mem[p+2] = 32'(blen);
    mem[p+3] = {16'(rq), 16'(nxt)};
  endtask

  task automatic enqueue(input logic [15:0] p);
    qPtr[qTail] = p;
    qTail = qTail + 4'd1;
  endtask

  task automatic waitPush(input int target, input string req);
    int t = 0;
    while (pN < target && t < 3000) begin @(negedge clk); t++; end
    repeat (3) @(negedge clk);
    chk(pN >= target, req, "push seen", pN, target);
  endtask

  // compare beats [b0, b0+n) against consecutive words from a buffer
  task automatic chkBeats(input int b0, input int at, input int addr, input int n,
                          input string req);
    for (int k = 0; k < n; k++)
      chk(bD[(b0 + at + k) % 256] == mem[addr + k], req, "beat data",
          bD[(b0 + at + k) % 256], mem[addr + k]);
  endtask

  task automatic tReset();
    chk(!tValidO && !popO && !pushO && !memRdO, "R1", "outputs after reset",
        {tValidO, popO, pushO, memRdO}, 0);
  endtask

  task automatic tIdle();
    int r0 = rdN, p0 = popN, b0 = bN;
    repeat (20) @(negedge clk);
    chk(popN == p0 && rdN == r0 && bN == b0 && !tValidO, "R1", "idle activity",
        popN - p0 + rdN - r0, 0);
  endtask

  task automatic tSingle();
    int r0 = rdN, b0 = bN, p0 = pN, q0 = popN, lastCnt = 0;
    setDesc(16'h10, 6, 16'h80, 6, 0, 5);
    enqueue(16'h10);
    waitPush(p0 + 1, "R8");
    chk(popN == q0 + 1, "R2", "pop count", popN - q0, 1);
    for (int k = 0; k < 4; k++)
      chk(rdLog[(r0 + k) % 256] == 16'(16'h10 + k), "R2", "descriptor read addr",
          rdLog[(r0 + k) % 256], 16'h10 + k);
    chk(bN - b0 == 6, "R4", "beat count", bN - b0, 6);
    chkBeats(b0, 0, 16'h80, 6, "R4");
    for (int k = 0; k < 6; k++) if (bL[(b0 + k) % 256]) lastCnt++;
    chk(lastCnt == 1 && bL[(b0 + 5) % 256], "R7", "single last marker", lastCnt, 1);
    chk(pP[p0] == 16'h10, "R8", "push pointer", pP[p0], 16'h10);
    chk(pQ[p0] == 16'd5, "R3", "return queue from word 3 high half", pQ[p0], 5);
    chk(!pE[p0], "R8", "error flag", pE[p0], 0);
  endtask

  task automatic tChain();
    int r0 = rdN, b0 = bN, p0 = pN, bad = 0, lastCnt = 0;
    setDesc(16'h20, 7, 16'h90, 3, 16'h24, 9);
    setDesc(16'h24, 99, 16'hA0, 0, 16'h28, 16'h66);
    setDesc(16'h28, 99, 16'hB0, 4, 0, 16'h77);
    enqueue(16'h20);
    waitPush(p0 + 1, "R5");
    chk(bN - b0 == 7, "R5", "chained beat count", bN - b0, 7);
    chkBeats(b0, 0, 16'h90, 3, "R5");
    chkBeats(b0, 3, 16'hB0, 4, "R5");
    for (int k = r0; k < rdN; k++)
      if (rdLog[k % 256] == 16'h24 || rdLog[k % 256] == 16'h28) bad++;
    chk(bad == 0, "R5", "reads of chained word 0", bad, 0);
    for (int k = 0; k < 7; k++) if (bL[(b0 + k) % 256]) lastCnt++;
    chk(lastCnt == 1 && bL[(b0 + 6) % 256], "R7", "chain last marker", lastCnt, 1);
    chk(pQ[p0] == 16'd9, "R8", "queue from first link", pQ[p0], 9);
    chk(pP[p0] == 16'h20 && !pE[p0], "R8", "chain push ptr", pP[p0], 16'h20);
  endtask

  task automatic tTrunc();
    int r0 = rdN, b0 = bN, p0 = pN, bad = 0;
    setDesc(16'h30, 2, 16'hC0, 5, 16'h40, 4);
    enqueue(16'h30);
    waitPush(p0 + 1, "R6");
    chk(bN - b0 == 2, "R6", "truncated beat count", bN - b0, 2);
    chkBeats(b0, 0, 16'hC0, 2, "R6");
    chk(bL[(b0 + 1) % 256], "R7", "truncated last marker", bL[(b0 + 1) % 256], 1);
    for (int k = r0; k < rdN; k++)
      if (rdLog[k % 256] >= 16'h40 && rdLog[k % 256] <= 16'h43) bad++;
    chk(bad == 0 && rdN - r0 == 6, "R6", "reads after length met", rdN - r0, 6);
  endtask

  task automatic tShort();
    int b0 = bN, p0 = pN, lastCnt = 0;
    setDesc(16'h34, 10, 16'hD0, 3, 0, 3);
    enqueue(16'h34);
    waitPush(p0 + 1, "R9");
    chk(bN - b0 == 3, "R9", "short chain beats", bN - b0, 3);
    chkBeats(b0, 0, 16'hD0, 3, "R9");
    for (int k = 0; k < 3; k++) if (bL[(b0 + k) % 256]) lastCnt++;
    chk(lastCnt == 0, "R9", "no last marker", lastCnt, 0);
    chk(pE[p0] && pP[p0] == 16'h34 && pQ[p0] == 16'd3, "R9", "error push",
        {pE[p0], pP[p0]}, {1'b1, 16'h34});
  endtask

  task automatic tStall();
    int b0 = bN, p0 = pN, s0 = stallRd, h0 = holdBad, t = 0;
    setDesc(16'h38, 5, 16'hE0, 5, 0, 2);
    enqueue(16'h38);
    while (pN < p0 + 1 && t < 3000) begin
      @(negedge clk);
      tReadyI = ((t * 7) % 5) < 2;
      t++;
    end
    tReadyI = 1'b1;
    repeat (3) @(negedge clk);
    chk(pN == p0 + 1, "R10", "push under stall", pN - p0, 1);
    chk(bN - b0 == 5, "R10", "beats under stall", bN - b0, 5);
    chkBeats(b0, 0, 16'hE0, 5, "R10");
    chk(stallRd == s0, "R10", "reads while stalled", stallRd - s0, 0);
    chk(holdBad == h0, "R10", "beat changed while stalled", holdBad - h0, 0);
  endtask

  task automatic tBackToBack();
    int b0 = bN, p0 = pN;
    setDesc(16'h44, 2, 16'hF0, 2, 0, 1);
    setDesc(16'h48, 3, 16'hF8, 3, 0, 2);
    enqueue(16'h44);
    enqueue(16'h48);
    waitPush(p0 + 2, "R11");
    chk(pP[p0] == 16'h44 && pP[p0 + 1] == 16'h48, "R11", "push order",
        {pP[p0], pP[p0 + 1]}, {16'h44, 16'h48});
    chk(pQ[p0] == 16'd1 && pQ[p0 + 1] == 16'd2, "R11", "push queues",
        {pQ[p0], pQ[p0 + 1]}, {16'd1, 16'd2});
    chk(bN - b0 == 5, "R11", "total beats", bN - b0, 5);
    chkBeats(b0, 0, 16'hF0, 2, "R11");
    chkBeats(b0, 2, 16'hF8, 3, "R11");
    chk(bL[(b0 + 1) % 256] && bL[(b0 + 4) % 256] && !bL[(b0 + 2) % 256], "R7",
        "per-packet last", {bL[(b0 + 1) % 256], bL[(b0 + 4) % 256]}, 3);
    chk(!qPendingI, "R11", "queue drained", qPendingI, 0);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 32'hD000_0000 | 32'(i);
    for (int i = 0; i < 16; i++) qPtr[i] = '0;
    repeat (3) @(negedge clk);
    tReset();
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tIdle();
    tSingle();
    tChain();
    tTrunc();
    tShort();
    tStall();
    tBackToBack();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog run did not finish actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule